// File: doc/BRIEF.md
# DMA Cycle Timing Controller

This block shapes the command strobes of DMA transfers on an AT-style I/O bus. It derives a DMA clock enable from the bus clock, either every other bus clock (half rate, the reset default) or every bus clock (full rate). Each transfer it accepts drives either a read or a write command strobe. The strobe stays active for a base of two DMA clock periods plus a programmed number of wait states. Separate wait-state counts apply to 8-bit and 16-bit cycles.

All timing settings sit in one 8-bit configuration register at index 01h. When the programmed wait states are used up, an active-low ready input can hold the strobe further. A one-bus-clock done pulse marks the end of each cycle. A request still present after done is accepted on the next DMA clock enable. A change of the rate setting only takes effect between cycles.

Top module: `dma_tmg_top`

## Requirements
- R1: After reset, both command strobes and done are low, and the register at index 01h reads 00h, which means half rate and zero wait states for both widths.
- R2: A write with cfg_addr = 01h stores all eight data bits, and the value reads back unchanged. A write to any other index leaves the register unchanged. A read of any other index returns 00h.
- R3: At full rate (register bit 0 = 1), an 8-bit cycle holds its strobe for 2 + W8 bus clocks, where W8 is register bits 3:2.
- R4: A 16-bit cycle (req_wide = 1) takes its wait-state count W16 from register bits 5:4 instead of bits 3:2.
- R5: At half rate (register bit 0 = 0), the strobe lasts 2 × (2 + W) bus clocks, because the DMA clock enable is active on every other bus clock.
- R6: req_write = 0 drives cmd_rd and req_write = 1 drives cmd_wr. The two strobes are never active together.
- R7: If rdy_n is high once the programmed wait states have elapsed, the strobe stays active. It ends at the first DMA clock enable at which rdy_n is low.
- R8: done is high for exactly one bus clock, in the same bus clock in which the strobe first reads low.
- R9: A write to register bit 0 during an active strobe does not change the length of that cycle. The following cycle uses the new rate.
- R10: A request held high across the end of a cycle starts the next strobe at the next DMA clock enable. This leaves a gap of one bus clock at full rate and two at half rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register index for write and read |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (combinational) |
| req | input | 1 | Cycle request, sampled on a DMA clock enable while idle |
| req_wide | input | 1 | 1 = 16-bit cycle, 0 = 8-bit cycle |
| req_write | input | 1 | 1 = write strobe, 0 = read strobe |
| rdy_n | input | 1 | Active-low ready; high extends the cycle |
| cmd_rd | output | 1 | Read command strobe, active high |
| cmd_wr | output | 1 | Write command strobe, active high |
| done | output | 1 | One-bus-clock pulse at the end of a cycle |

## Verification
A request is taken at a DMA clock enable. The strobe rises in the bus clock after that edge and stays up for exactly 2 + W enables. At the falling edge of each bus clock, the bench counts the clocks in which the strobe is high and compares the count with 2 + W or 2 × (2 + W). It checks done in the first low sample and again one sample later. The ready release, the rate change in mid-cycle and the held request are each driven at a known sample inside this count. The expected lengths of 6 (ready held), 4 (half rate kept despite the write) and gaps of 1 or 2 bus clocks come straight from that latency. Register reads are sampled shortly after the address settles, since the read path is combinational.

// File: rtl/dma_tmg_pkg.sv
package dma_tmg_pkg;

    localparam int CFG_W      = 8;
    localparam int WS_W       = 2;
    localparam int CNT_W      = WS_W + 1;
    localparam int FULL_BIT   = 0;
    localparam int WS8_LSB    = 2;
    localparam int WS16_LSB   = 4;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CMD  = 1'b1
    } seq_state_t;

    typedef struct packed {
        logic wide;
        logic write;
    } cyc_attr_t;

    typedef struct packed {
        logic            full_rate;
        logic [WS_W-1:0] ws8;
        logic [WS_W-1:0] ws16;
    } tmg_cfg_t;

    function automatic tmg_cfg_t decode_cfg(input logic [CFG_W-1:0] r);
        tmg_cfg_t c;
        c.full_rate = r[FULL_BIT];
        c.ws8       = r[WS8_LSB +: WS_W];
        c.ws16      = r[WS16_LSB +: WS_W];
        return c;
    endfunction

    function automatic logic [CNT_W-1:0] start_count(input logic [WS_W-1:0] ws);
        return CNT_W'(ws) + CNT_W'(1);
    endfunction

endpackage

// File: rtl/dma_tmg_cfg.sv
module dma_tmg_cfg
    import dma_tmg_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = CFG_W,
    parameter int CFG_IDX = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DATA_W-1:0] reg_o
);
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(CFG_IDX);

    logic [DATA_W-1:0] reg_q;
    logic              hit;

    assign hit = (addr_i == IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q <= '0;
        end else if (wr_i && hit) begin
            reg_q <= wdata_i;
        end
    end

    assign rdata_o = hit ? reg_q : '0;
    assign reg_o   = reg_q;

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr_i && hit) |=> $stable(reg_q)); // R2

endmodule

// File: rtl/dma_tmg_clkgen.sv
module dma_tmg_clkgen (
    input  logic clk,
    input  logic rst,
    input  logic full_cfg_i,
    input  logic busy_i,
    output logic tick_o
);
    logic div_q;
    logic full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= 1'b0;
            full_q <= 1'b0;
        end else begin
            div_q <= ~div_q;
            if (!busy_i) begin
                full_q <= full_cfg_i;
            end
        end
    end

    assign tick_o = full_q | div_q;

    AST_RATE_HELD: assert property (@(posedge clk) disable iff (rst)
        busy_i |=> $stable(full_q)); // R9

    AST_HALF_TICK: assert property (@(posedge clk) disable iff (rst)
        (!full_q && tick_o) |=> (!tick_o || full_q)); // R5

endmodule

// File: rtl/dma_tmg_seq.sv
module dma_tmg_seq
    import dma_tmg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            tick_i,
    input  logic            req_i,
    input  logic            wide_i,
    input  logic            write_i,
    input  logic            rdy_n_i,
    input  logic [WS_W-1:0] ws8_i,
    input  logic [WS_W-1:0] ws16_i,
    output logic            rd_o,
    output logic            wr_o,
    output logic            done_o,
    output logic            busy_o
);
    seq_state_t       state_q;
    cyc_attr_t        cyc_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    logic [WS_W-1:0]  ws_sel;
    logic             active;

    assign ws_sel = wide_i ? ws16_i : ws8_i;
    assign active = (state_q == ST_CMD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cyc_q   <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (tick_i) begin
                case (state_q)
                    ST_IDLE: begin
                        if (req_i) begin
                            state_q     <= ST_CMD;
                            cyc_q.wide  <= wide_i;
                            cyc_q.write <= write_i;
                            cnt_q       <= start_count(ws_sel);
                        end
                    end
                    ST_CMD: begin
                        if (cnt_q != '0) begin
                            cnt_q <= cnt_q - CNT_W'(1);
                        end else if (!rdy_n_i) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign rd_o   = active && !cyc_q.write;
    assign wr_o   = active &&  cyc_q.write;
    assign done_o = done_q;
    assign busy_o = active;

    AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o))); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R8

    AST_RDY_EXTENDS: assert property (@(posedge clk) disable iff (rst)
        (busy_o && cnt_q == '0 && rdy_n_i) |=> busy_o); // R7

    AST_WIDTH_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(cyc_q)); // R4

endmodule

// File: rtl/dma_tmg_top.sv
module dma_tmg_top
    import dma_tmg_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int CFG_IDX = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              req,
    input  logic              req_wide,
    input  logic              req_write,
    input  logic              rdy_n,
    output logic              cmd_rd,
    output logic              cmd_wr,
    output logic              done
);
    logic [CFG_W-1:0] reg_val;
    tmg_cfg_t         cfg;
    logic             tick;
    logic             busy;

    dma_tmg_cfg #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (CFG_W),
        .CFG_IDX (CFG_IDX)
    ) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (cfg_wr),
        .addr_i  (cfg_addr),
        .wdata_i (cfg_wdata),
        .rdata_o (cfg_rdata),
        .reg_o   (reg_val)
    );

    assign cfg = decode_cfg(reg_val);

    dma_tmg_clkgen u_clk (
        .clk        (clk),
        .rst        (rst),
        .full_cfg_i (cfg.full_rate),
        .busy_i     (busy),
        .tick_o     (tick)
    );

    dma_tmg_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick),
        .req_i   (req),
        .wide_i  (req_wide),
        .write_i (req_write),
        .rdy_n_i (rdy_n),
        .ws8_i   (cfg.ws8),
        .ws16_i  (cfg.ws16),
        .rd_o    (cmd_rd),
        .wr_o    (cmd_wr),
        .done_o  (done),
        .busy_o  (busy)
    );

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(cmd_rd && cmd_wr)); // R6

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!cmd_rd && !cmd_wr && !done)); // R1

endmodule

// File: tb/dma_tmg_top_tb.sv
module dma_tmg_top_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_wr;
    logic [7:0] cfg_addr;
    logic [7:0] cfg_wdata;
    logic [7:0] cfg_rdata;
    logic       req;
    logic       req_wide;
    logic       req_write;
    logic       rdy_n;
    logic       cmd_rd;
    logic       cmd_wr;
    logic       done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dma_tmg_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .req       (req),
        .req_wide  (req_wide),
        .req_write (req_write),
        .rdy_n     (rdy_n),
        .cmd_rd    (cmd_rd),
        .cmd_wr    (cmd_wr),
        .done      (done)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_addr = 8'h01;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
        cfg_addr = 8'h01;
    endtask

    // One cycle: rel > 0 holds rdy_n high until that many strobe samples;
    // flip >= 0 writes that value to the register at the first strobe sample.
    task automatic run_cyc(input string tag, input bit wide, input bit wr,
                           input int rel, input int flip, input int exp_len);
        int n = 0;
        int len = 0;
        bit other = 0;
        @(negedge clk);
        req = 1'b1; req_wide = wide; req_write = wr;
        if (rel > 0) rdy_n = 1'b1;
        while (!(cmd_rd || cmd_wr) && n < 40) begin
            @(negedge clk);
            n++;
        end
        req = 1'b0;
        while ((cmd_rd || cmd_wr) && len < 100) begin
            if (wr ? cmd_rd : cmd_wr) other = 1;
            if (wr ? !cmd_wr : !cmd_rd) other = 1;
            len++;
            if (rel > 0 && len == rel) rdy_n = 1'b0;
            if (flip >= 0 && len == 1) begin
                cfg_wr = 1'b1; cfg_addr = 8'h01; cfg_wdata = 8'(flip);
            end
            if (len == 2) cfg_wr = 1'b0;
            @(negedge clk);
        end
        cfg_wr = 1'b0;
        rdy_n = 1'b0;
        check({tag, " strobe length"}, len, exp_len);
        check({tag, " R6 correct strobe only"}, int'(other), 0);
        check({tag, " R8 done at fall"}, int'(done), 1);
        @(negedge clk);
        check({tag, " R8 done single"}, int'(done), 0);
    endtask

    task automatic run_b2b(input string tag, input int exp_gap);
        int n = 0;
        int gap = 0;
        @(negedge clk);
        req = 1'b1; req_wide = 1'b0; req_write = 1'b0;
        while (!cmd_rd && n < 40) begin @(negedge clk); n++; end
        n = 0;
        while (cmd_rd && n < 40) begin @(negedge clk); n++; end
        while (!cmd_rd && gap < 40) begin @(negedge clk); gap++; end
        req = 1'b0;
        n = 0;
        while (cmd_rd && n < 40) begin @(negedge clk); n++; end
        repeat (2) @(negedge clk);
        check({tag, " R10 gap"}, gap, exp_gap);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        @(negedge clk);
        check("R1 cmd_rd", int'(cmd_rd), 0);
        check("R1 cmd_wr", int'(cmd_wr), 0);
        check("R1 done", int'(done), 0);
        reg_read(8'h01, d);
        check("R1 reg", int'(d), 0);
        run_cyc("R1 default half zero-wait", 1'b0, 1'b0, 0, -1, 4);
    endtask

    task automatic t_reg;
        logic [7:0] d;
        reg_write(8'h01, 8'hA5);
        reg_read(8'h01, d);
        check("R2 readback", int'(d), 8'hA5);
        reg_write(8'h02, 8'hFF);
        reg_read(8'h01, d);
        check("R2 other index ignored", int'(d), 8'hA5);
        reg_read(8'h02, d);
        check("R2 other index reads zero", int'(d), 0);
    endtask

    task automatic t_full8;
        reg_write(8'h01, 8'h09);
        run_cyc("R3 full 8-bit read W8=2", 1'b0, 1'b0, 0, -1, 4);
        run_cyc("R3 full 8-bit write W8=2", 1'b0, 1'b1, 0, -1, 4);
    endtask

    task automatic t_wide;
        reg_write(8'h01, 8'h35);
        run_cyc("R4 full 16-bit W16=3", 1'b1, 1'b1, 0, -1, 5);
        run_cyc("R4 full 8-bit W8=1", 1'b0, 1'b0, 0, -1, 3);
    endtask

    task automatic t_half;
        reg_write(8'h01, 8'h34);
        run_cyc("R5 half 16-bit W16=3", 1'b1, 1'b0, 0, -1, 10);
        run_cyc("R5 half 8-bit W8=1", 1'b0, 1'b1, 0, -1, 6);
    endtask

    task automatic t_ready;
        reg_write(8'h01, 8'h01);
        run_cyc("R7 ready held", 1'b0, 1'b0, 6, -1, 6);
        run_cyc("R7 ready low", 1'b0, 1'b0, 0, -1, 2);
    endtask

    task automatic t_rate_change;
        reg_write(8'h01, 8'h00);
        run_cyc("R9 half kept during write", 1'b0, 1'b0, 0, 1, 4);
        run_cyc("R9 next cycle full", 1'b0, 1'b0, 0, -1, 2);
    endtask

    task automatic t_b2b;
        reg_write(8'h01, 8'h01);
        run_b2b("R10 full", 1);
        reg_write(8'h01, 8'h00);
        run_b2b("R10 half", 2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_wr = 1'b0; cfg_addr = 8'h01; cfg_wdata = 8'h00;
        req = 1'b0; req_wide = 1'b0; req_write = 1'b0; rdy_n = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_reg();
        t_full8();
        t_wide();
        t_half();
        t_ready();
        t_rate_change();
        t_b2b();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule